// File: doc/BRIEF.md
# Grouped Edge-Detect Pin Interrupt Controller

This block watches thirteen pin levels that have already been synchronized to its clock. For each pin it looks for a programmable edge: none, falling, rising or either. Each detected edge is latched into a sticky status bit. Software clears a status bit by writing a 1 to it.

The pins are split unevenly into two interrupt groups. Pins 0 to 6 form group 0 and pins 7 to 12 form group 1. Each group has one status byte and one mask byte. A single active-high interrupt line stays asserted for as long as any status bit whose mask bit is 0 remains set.

Software reaches the block over a byte-wide register bus. Writes are strobed and reads are combinational. Each pin has its own control byte, which holds the edge selection and shows the live pin level. After reading both status bytes, software forms the 13-bit pending set as group 0 bits 6:0 in positions 6:0 and group 1 bits 5:0 in positions 12:7.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, every status bit is 0, every implemented mask bit is 1, every pin edge code is 00, and `irq_o` is 0.
- R2: The edge code of a pin is held in bits 2:1 of its control byte. Code 00 detects nothing, 01 detects falling edges, 10 detects rising edges and 11 detects both. A detected edge is visible in the status byte after the first rising clock edge that samples the new pin level.
- R3: A detected edge sets its status bit whatever the state of that pin's mask bit.
- R4: Writing a status byte clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R5: When a pin edge is detected in the same cycle as a write of 1 to that pin's status bit, the bit stays set.
- R6: `irq_o` is a level that is 1 exactly while some status bit is set and its mask bit is 0. A mask bit of 1 suppresses that pin. Mask bytes are plain read/write.
- R7: Status and mask bits with no pin read as 0 and ignore writes. These are group 0 bit 7 and group 1 bits 7:6.
- R8: Group 0 status is at address 0x00 and group 1 status at 0x01. Group 0 mask is at 0x02 and group 1 mask at 0x03. Pin n (n = 0..6) uses bit n of the group 0 bytes, and pin n (n = 7..12) uses bit n-7 of the group 1 bytes.
- R9: The control byte of pin n is at address 0x10+n. Bit 0 reads the current pin level and is read-only, bits 2:1 are the edge code, and bits 7:3 read 0. Every address not listed here reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_lvl_i | input | 13 | Synchronized pin levels |
| bus_addr_i | input | 8 | Register address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
A wrong edge decoder or a wrong group bit mapping shows up in the very next status read after a pin toggle. The bit appears in the wrong pending position, or fails to appear, one clock after the level change. A status register that loses its value through a bad clear priority or a corrupted mask shows on `irq_o` in the same cycle. The bench sweeps every pin against every edge code and both transition directions so that each such fault is seen within a few cycles.

// File: rtl/pei_pkg.sv
package pei_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Bit 1 of the code arms rising edges, bit 0 arms falling edges.
  function automatic logic edge_hit(input edge_sel_e sel, input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    return (sel[1] & rise) | (sel[0] & fall);
  endfunction

endpackage

// File: rtl/pei_edge_cell.sv
module pei_edge_cell
  import pei_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_wdata_i,
  output logic [1:0] cfg_o,
  output logic       evt_o
);

  logic      prev_q;
  logic      prev_d;
  edge_sel_e sel_q;
  edge_sel_e sel_d;

  always_comb begin
    prev_d = lvl_i;
    sel_d  = sel_q;
    if (cfg_we_i) begin
      sel_d = edge_sel_e'(cfg_wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= EDGE_OFF;
    end else begin
      prev_q <= prev_d;
      sel_q  <= sel_d;
    end
  end

  assign evt_o = edge_hit(sel_q, prev_q, lvl_i);
  assign cfg_o = sel_q;

endmodule

// File: rtl/pei_event_regs.sv
module pei_event_regs #(
  parameter int NUM_PINS = 13,
  parameter int G0_PINS  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [1:0]          stat_wr_i,
  input  logic [1:0]          mask_wr_i,
  input  logic [7:0]          wdata_i,
  output logic [NUM_PINS-1:0] stat_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] stat_q;
  logic [NUM_PINS-1:0] stat_d;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] mask_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    localparam int GRP = (i < G0_PINS) ? 0 : 1;
    localparam int LB  = (i < G0_PINS) ? i : i - G0_PINS;

    logic clr;
    assign clr = stat_wr_i[GRP] & wdata_i[LB];

    always_comb begin
      // A new event takes priority over a clear of the same bit.
      stat_d[i] = evt_i[i] | (stat_q[i] & ~clr);
      mask_d[i] = mask_wr_i[GRP] ? wdata_i[LB] : mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);

endmodule

// File: rtl/pei_reg_decode.sv
module pei_reg_decode #(
  parameter int         NUM_PINS  = 13,
  parameter int         G0_PINS   = 7,
  parameter logic [7:0] STAT_ADDR = 8'h00,
  parameter logic [7:0] MASK_ADDR = 8'h02,
  parameter logic [7:0] CFG_ADDR  = 8'h10
) (
  input  logic [7:0]              addr_i,
  input  logic                    we_i,
  input  logic [NUM_PINS-1:0]     stat_i,
  input  logic [NUM_PINS-1:0]     mask_i,
  input  logic [NUM_PINS-1:0][1:0] cfg_i,
  input  logic [NUM_PINS-1:0]     lvl_i,
  output logic [1:0]              stat_wr_o,
  output logic [1:0]              mask_wr_o,
  output logic [NUM_PINS-1:0]     cfg_we_o,
  output logic [7:0]              rdata_o
);

  localparam int G1_PINS = NUM_PINS - G0_PINS;

  logic [7:0] stat_b0;
  logic [7:0] stat_b1;
  logic [7:0] mask_b0;
  logic [7:0] mask_b1;

  always_comb begin
    stat_b0 = '0;
    stat_b1 = '0;
    mask_b0 = '0;
    mask_b1 = '0;
    stat_b0[G0_PINS-1:0] = stat_i[G0_PINS-1:0];
    mask_b0[G0_PINS-1:0] = mask_i[G0_PINS-1:0];
    stat_b1[G1_PINS-1:0] = stat_i[NUM_PINS-1:G0_PINS];
    mask_b1[G1_PINS-1:0] = mask_i[NUM_PINS-1:G0_PINS];
  end

  always_comb begin
    stat_wr_o[0] = we_i & (addr_i == STAT_ADDR);
    stat_wr_o[1] = we_i & (addr_i == STAT_ADDR + 8'd1);
    mask_wr_o[0] = we_i & (addr_i == MASK_ADDR);
    mask_wr_o[1] = we_i & (addr_i == MASK_ADDR + 8'd1);
    for (int n = 0; n < NUM_PINS; n++) begin
      cfg_we_o[n] = we_i & (addr_i == CFG_ADDR + 8'(n));
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_ADDR)              rdata_o = stat_b0;
    else if (addr_i == STAT_ADDR + 8'd1)  rdata_o = stat_b1;
    else if (addr_i == MASK_ADDR)         rdata_o = mask_b0;
    else if (addr_i == MASK_ADDR + 8'd1)  rdata_o = mask_b1;
    else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (addr_i == CFG_ADDR + 8'(n)) begin
          rdata_o = {5'b0, cfg_i[n], lvl_i[n]};
        end
      end
    end
  end

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int         NUM_PINS  = 13,
  parameter int         G0_PINS   = 7,
  parameter logic [7:0] STAT_ADDR = 8'h00,
  parameter logic [7:0] MASK_ADDR = 8'h02,
  parameter logic [7:0] CFG_ADDR  = 8'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  input  logic [7:0]          bus_addr_i,
  input  logic                bus_we_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0]      evt;
  logic [NUM_PINS-1:0]      stat_q;
  logic [NUM_PINS-1:0]      mask_q;
  logic [NUM_PINS-1:0][1:0] cfg;
  logic [NUM_PINS-1:0]      cfg_we;
  logic [1:0]               stat_wr;
  logic [1:0]               mask_wr;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pei_edge_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_i       (pin_lvl_i[n]),
      .cfg_we_i    (cfg_we[n]),
      .cfg_wdata_i (bus_wdata_i[2:1]),
      .cfg_o       (cfg[n]),
      .evt_o       (evt[n])
    );
  end

  pei_event_regs #(
    .NUM_PINS (NUM_PINS),
    .G0_PINS  (G0_PINS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .stat_wr_i (stat_wr),
    .mask_wr_i (mask_wr),
    .wdata_i   (bus_wdata_i),
    .stat_o    (stat_q),
    .mask_o    (mask_q),
    .irq_o     (irq_o)
  );

  pei_reg_decode #(
    .NUM_PINS  (NUM_PINS),
    .G0_PINS   (G0_PINS),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR),
    .CFG_ADDR  (CFG_ADDR)
  ) u_dec (
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .stat_i    (stat_q),
    .mask_i    (mask_q),
    .cfg_i     (cfg),
    .lvl_i     (pin_lvl_i),
    .stat_wr_o (stat_wr),
    .mask_wr_o (mask_wr),
    .cfg_we_o  (cfg_we),
    .rdata_o   (bus_rdata_o)
  );

endmodule

// File: rtl/pei_checker.sv
module pei_checker #(
  parameter int         NUM_PINS  = 13,
  parameter logic [7:0] STAT_ADDR = 8'h00
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] stat_q,
  input logic                irq,
  input logic [7:0]          addr,
  input logic [7:0]          rdata
);

  // R1: the interrupt is low throughout reset
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      a_r1_reset_quiet: assert (irq == 1'b0);
    end
  end

  // R3, R5: every event leaves its status bit set in the next cycle
  a_r5_event_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R2: a status bit only rises when an event was seen
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

  // R6: the interrupt needs at least one status bit
  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(stat_q) != 0));

  // R7: unused group 1 bits read 0
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_ADDR + 8'd1) |-> (rdata[7:6] == 2'b00));

endmodule

bind pin_edge_irq pei_checker #(
  .NUM_PINS  (NUM_PINS),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .evt    (evt),
  .stat_q (stat_q),
  .irq    (irq_o),
  .addr   (bus_addr_i),
  .rdata  (bus_rdata_o)
);

// File: tb/pin_edge_irq_tb.sv
module pin_edge_irq_tb;

  localparam logic [7:0] S0 = 8'h00;
  localparam logic [7:0] S1 = 8'h01;
  localparam logic [7:0] M0 = 8'h02;
  localparam logic [7:0] M1 = 8'h03;
  localparam logic [7:0] CB = 8'h10;

  logic        clk;
  logic        rst_n;
  logic [12:0] pins;
  logic [7:0]  addr;
  logic        we;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq;

  int n_chk;
  int n_fail;

  pin_edge_irq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl_i   (pins),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pending(output int v);
    logic [7:0] b0;
    logic [7:0] b1;
    rd(S0, b0);
    rd(S1, b1);
    v = int'(b0[6:0]) | (int'(b1[5:0]) << 7);
  endtask

  task automatic clear_all();
    wr(S0, 8'hFF);
    wr(S1, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int v;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; pins = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(S0, d); chk("R1 status0", d, 8'h00);
    rd(S1, d); chk("R1 status1", d, 8'h00);
    rd(M0, d); chk("R1 mask0", d, 8'h7F);
    rd(M1, d); chk("R1 mask1", d, 8'h3F);
    for (int p = 0; p < 13; p++) begin
      rd(CB + 8'(p), d); chk("R1 cfg", d, 0);
    end
    chk("R1 irq", irq, 0);

    // R2 R3 R8 R9 sweep of every pin, code and direction (all masked)
    for (int p = 0; p < 13; p++) begin
      for (int c = 0; c < 4; c++) begin
        wr(CB + 8'(p), 8'(c << 1));
        rd(CB + 8'(p), d); chk("R9 cfg readback low", d, c << 1);
        @(negedge clk); pins[p] = 1'b1;
        @(negedge clk);
        pending(v); chk("R2 R8 rising", v, (c >> 1) ? (1 << p) : 0);
        chk("R3 masked irq low", irq, 0);
        rd(CB + 8'(p), d); chk("R9 cfg level bit", d, (c << 1) | 1);
        clear_all();
        @(negedge clk); pins[p] = 1'b0;
        @(negedge clk);
        pending(v); chk("R2 R8 falling", v, (c & 1) ? (1 << p) : 0);
        clear_all();
        wr(CB + 8'(p), 8'h00);
      end
    end

    // R9: unused bits of the control byte read 0
    wr(CB + 8'd4, 8'hFF);
    rd(CB + 8'd4, d); chk("R9 cfg unused bits", d, 8'h06);

    // Arm both edges on every pin and toggle all of them
    for (int p = 0; p < 13; p++) wr(CB + 8'(p), 8'h06);
    @(negedge clk); pins = '1;
    @(negedge clk);
    pending(v); chk("R3 all set while masked", v, 13'h1FFF);

    // R4 write-one-to-clear
    wr(S0, 8'h00);
    rd(S0, d); chk("R4 zero write keeps", d, 8'h7F);
    wr(S0, 8'h05);
    rd(S0, d); chk("R4 clear bits 0,2", d, 8'h7A);
    wr(S1, 8'hC1);
    rd(S1, d); chk("R4 R7 clear group1 bit0", d, 8'h3E);

    // R5 edge and clear in the same cycle
    @(negedge clk);
    pins[3] = 1'b0; pins[4] = 1'b0;
    addr = S0; wdata = 8'h18; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(S0, d); chk("R5 set wins", d, 8'h7A);
    wr(S0, 8'h18);
    rd(S0, d); chk("R5 control clear", d, 8'h62);

    // R6 mask and interrupt level
    chk("R6 all masked", irq, 0);
    wr(M1, 8'hFF);
    rd(M1, d); chk("R7 mask1 unused", d, 8'h3F);
    wr(M1, 8'h3E);
    chk("R6 unmask unset bit", irq, 0);
    wr(M1, 8'h3D);
    chk("R6 unmask set bit", irq, 1);
    @(negedge clk);
    chk("R6 level held", irq, 1);
    wr(S1, 8'h02);
    chk("R6 cleared drops irq", irq, 0);
    wr(M0, 8'h00);
    chk("R6 group0 unmasked", irq, 1);
    rd(M0, d); chk("R7 mask0 readback", d, 8'h00);
    clear_all();
    chk("R6 all clear", irq, 0);

    // R7 R9 unmapped addresses
    rd(8'h08, d); chk("R9 unmapped", d, 0);
    rd(CB + 8'd13, d); chk("R9 past last pin", d, 0);
    wr(S0, 8'h80);
    rd(S0, d); chk("R7 status0 bit7", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule